// File: doc/BRIEF.md
# Timer Time Base with Buffered Reload

This block is the counting core of a general-purpose timer. A programmable prescaler divides the system clock. The divided ticks drive a counter that runs up, runs down, or swings between zero and a limit value. Software writes the division value and the limit into buffer registers. Those values become active only when an update event occurs, so a running period is never cut short by a write that lands part of the way through it.

An update event happens when the counter wraps, or when software writes the update strobe. A software update restarts both the counter and the prescaler's internal count. A control bit lets software run such an update silently, without setting the flag. The update flag stays set until software clears it. The interrupt line is the flag gated by an enable bit.

Top module: `tmr_timebase`

## Requirements
- R1: After a synchronous active-low reset, the counter reads 0, the update flag is 0, the interrupt is 0 and counting is disabled.
- R2: Writes select a register by address. Address 0 is control: bit 0 enable, bit 1 quiet-update select, bits 3:2 mode (0 up, 1 down, 2 center, 3 behaves as up), bit 4 interrupt enable. Address 1 is the division buffer. Address 2 is the limit buffer. Address 3 is the command register: bit 0 = 1 issues a software update, and bit 1 = 0 clears the flag.
- R3: In up mode, each tick adds 1 to the counter. A tick that finds the counter at the active limit instead loads 0 and raises an update event.
- R4: In down mode, each tick subtracts 1 from the counter. A tick at 0 raises an update event and reloads the counter with the limit buffer value, which becomes active on that same event.
- R5: In center mode, the counter climbs from 0. The tick that takes it from limit−1 to the limit raises an overflow event and turns the direction downward. The tick that takes it from 1 to 0 raises an underflow event and turns the direction upward.
- R6: With an active division value P, the counter advances once every P+1 enabled clock cycles.
- R7: Writes to the division and limit buffers have no effect until an update event copies them into the active registers. The period that follows the event already uses the new limit.
- R8: A software update loads the counter with 0 (up and center modes) or with the limit buffer value (down mode). It restarts the prescaler count at 0 and performs the buffer-to-active transfers. It also works while counting is disabled.
- R9: When quiet-update select is 1, a software update does not set the flag. When it is 0, a software update sets the flag.
- R10: A wrap event sets the update flag, and the flag stays set until a command write with bit 1 = 0. If a set and a clear arrive in the same cycle, the set wins.
- R11: The interrupt output equals the flag ANDed with the interrupt enable.
- R12: While the enable bit is 0, neither the prescaler nor the counter moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | DATA_W | Write data, where DATA_W is the larger of CNT_W and PSC_W |
| cnt_o | output | CNT_W | Current counter value |
| upd_flag | output | 1 | Sticky update flag |
| irq | output | 1 | Update interrupt |

## Verification
The bench builds the block with CNT_W = 8 and PSC_W = 4. A limit of 0x36 then fits, and many full periods at divide-by-1 and divide-by-4 complete within a short run. Wraps in all three modes can be observed, including the center-mode turnarounds. The narrow counter also keeps the expected-value arithmetic, including the modulo for down mode, easy to confirm by hand.

// File: rtl/tmr_pkg.sv
// Package: shared mode encoding and register addresses for the time base.
// Assumes a two-bit register address space.
package tmr_pkg;
    typedef enum logic [1:0] {
        MODE_UP     = 2'd0,
        MODE_DOWN   = 2'd1,
        MODE_CENTER = 2'd2,
        MODE_UP_ALT = 2'd3
    } cnt_mode_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_PSC  = 2'd1;
    localparam logic [1:0] ADDR_ARR  = 2'd2;
    localparam logic [1:0] ADDR_CMD  = 2'd3;

    localparam int CTRL_EN   = 0;
    localparam int CTRL_URS  = 1;
    localparam int CTRL_MODE = 2;
    localparam int CTRL_UIE  = 4;
    localparam int CMD_UG    = 0;
    localparam int CMD_KEEP  = 1;
endpackage

// File: rtl/tmr_regs.sv
// Register file: holds control, the two buffers and the sticky update flag.
// Decodes the software update strobe combinationally from the write port.
// Assumes DATA_W >= 5 so that all control bits fit.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              hw_evt,
    output logic              en,
    output logic              urs,
    output cnt_mode_e         mode,
    output logic              uie,
    output logic [PSC_W-1:0]  psc_buf,
    output logic [CNT_W-1:0]  arr_buf,
    output logic              ug,
    output logic              upd_flag
);
    logic cmd_wr;
    logic flag_set;
    logic flag_clr;

    // Decode the command write, the flag set request and the flag clear request.
    always_comb begin
        cmd_wr   = wr_en && (wr_addr == ADDR_CMD);
        ug       = cmd_wr && wr_data[CMD_UG];
        flag_set = hw_evt || (ug && !urs);
        flag_clr = cmd_wr && !wr_data[CMD_KEEP];
    end

    // Control register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en   <= 1'b0;
            urs  <= 1'b0;
            mode <= MODE_UP;
            uie  <= 1'b0;
        end else if (wr_en && wr_addr == ADDR_CTRL) begin
            en   <= wr_data[CTRL_EN];
            urs  <= wr_data[CTRL_URS];
            mode <= cnt_mode_e'(wr_data[CTRL_MODE +: 2]);
            uie  <= wr_data[CTRL_UIE];
        end
    end

    // Division and limit buffers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psc_buf <= '0;
            arr_buf <= '1;
        end else if (wr_en) begin
            if (wr_addr == ADDR_PSC) psc_buf <= wr_data[PSC_W-1:0];
            if (wr_addr == ADDR_ARR) arr_buf <= wr_data[CNT_W-1:0];
        end
    end

    // Sticky update flag, with set taking priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        upd_flag <= 1'b0;
        else if (flag_set) upd_flag <= 1'b1;
        else if (flag_clr) upd_flag <= 1'b0;
    end

    // R9
    quiet_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ug && urs && !hw_evt) |=> !$rose(upd_flag));
    // R10
    wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_evt |=> upd_flag);
endmodule

// File: rtl/tmr_prescaler.sv
// Prescaler: divides the clock by (active value + 1) and emits one tick per period.
// The active value is loaded from the buffer only on an update event.
// A software update restarts the internal count from zero.
module tmr_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             ug,
    input  logic             upd_evt,
    input  logic [PSC_W-1:0] psc_buf,
    output logic             tick
);
    logic [PSC_W-1:0] psc_act;
    logic [PSC_W-1:0] pcnt;
    logic             at_end;

    // Detect the end of a division period.
    always_comb begin
        at_end = (pcnt >= psc_act);
        tick   = en && !ug && at_end;
    end

    // Active division value, transferred on update events.
    always_ff @(posedge clk) begin
        if (!rst_n)       psc_act <= '0;
        else if (upd_evt) psc_act <= psc_buf;
    end

    // Internal divider count.
    always_ff @(posedge clk) begin
        if (!rst_n)      pcnt <= '0;
        else if (ug)     pcnt <= '0;
        else if (en)     pcnt <= at_end ? '0 : pcnt + 1'b1;
    end

    // R7
    psc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_evt |=> $stable(psc_act));
    // R8
    psc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ug |=> (pcnt == '0));
    // R12
    psc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !ug) |=> $stable(pcnt));
endmodule

// File: rtl/tmr_counter.sv
// Main counter: up, down or center counting on prescaler ticks.
// Produces the hardware wrap event and holds the active limit register.
// The active limit is loaded on every update event, and the down-mode reload
// takes the buffer value so that the next period uses the new limit.
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ug,
    input  logic             upd_evt,
    input  cnt_mode_e        mode,
    input  logic [CNT_W-1:0] arr_buf,
    output logic [CNT_W-1:0] cnt,
    output logic             hw_evt
);
    logic [CNT_W-1:0] arr_act;
    logic             dir_down;
    logic [CNT_W:0]   cnt_inc;

    // Find the wrap condition for the current mode and direction.
    always_comb begin
        cnt_inc = {1'b0, cnt} + 1'b1;
        unique case (mode)
            MODE_DOWN:   hw_evt = tick && (cnt == '0);
            MODE_CENTER: hw_evt = tick && (dir_down ? (cnt <= 1)
                                                    : (cnt_inc >= {1'b0, arr_act}));
            default:     hw_evt = tick && (cnt >= arr_act);
        endcase
    end

    // Active limit, transferred on update events.
    always_ff @(posedge clk) begin
        if (!rst_n)       arr_act <= '1;
        else if (upd_evt) arr_act <= arr_buf;
    end

    // Counter value and center-mode direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            dir_down <= 1'b0;
        end else if (ug) begin
            cnt      <= (mode == MODE_DOWN) ? arr_buf : '0;
            dir_down <= 1'b0;
        end else if (tick) begin
            unique case (mode)
                MODE_DOWN: begin
                    cnt      <= hw_evt ? arr_buf : cnt - 1'b1;
                    dir_down <= 1'b0;
                end
                MODE_CENTER: begin
                    cnt      <= dir_down ? cnt - 1'b1 : cnt + 1'b1;
                    dir_down <= hw_evt ? !dir_down : dir_down;
                end
                default: begin
                    cnt      <= hw_evt ? '0 : cnt + 1'b1;
                    dir_down <= 1'b0;
                end
            endcase
        end
    end

    // R7
    arr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_evt |=> $stable(arr_act));
    // R8
    ug_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ug && mode != MODE_DOWN) |=> (cnt == '0));
    // R3
    up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ug && mode == MODE_UP && cnt == arr_act) |=> (cnt == '0));
    // R12
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ug) |=> $stable(cnt));
endmodule

// File: rtl/tmr_timebase.sv
// Top level of the timer time base: register port, prescaler and counter.
// An update event is a hardware wrap or a software update strobe.
// Assumes max(CNT_W, PSC_W) >= 5 so that the control word fits the data port.
module tmr_timebase
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16,
    localparam int DATA_W = (CNT_W > PSC_W) ? CNT_W : PSC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              upd_flag,
    output logic              irq
);
    logic             en;
    logic             urs;
    cnt_mode_e        mode;
    logic             uie;
    logic [PSC_W-1:0] psc_buf;
    logic [CNT_W-1:0] arr_buf;
    logic             ug;
    logic             hw_evt;
    logic             upd_evt;
    logic             tick;

    // Merge the update sources and gate the interrupt.
    always_comb begin
        upd_evt = hw_evt || ug;
        irq     = upd_flag && uie;
    end

    tmr_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .hw_evt(hw_evt), .en(en), .urs(urs), .mode(mode),
        .uie(uie), .psc_buf(psc_buf), .arr_buf(arr_buf), .ug(ug),
        .upd_flag(upd_flag)
    );

    tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .en(en), .ug(ug), .upd_evt(upd_evt),
        .psc_buf(psc_buf), .tick(tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ug(ug), .upd_evt(upd_evt),
        .mode(mode), .arr_buf(arr_buf), .cnt(cnt_o), .hw_evt(hw_evt)
    );
endmodule

// File: tb/tmr_timebase_test.sv
module tmr_timebase_test;
    localparam int CNT_W = 8;
    localparam int PSC_W = 4;
    localparam int DW    = 8;
    localparam int NV    = 9;

    // Table columns: mode, division value, limit, enabled cycles to run.
    localparam int V_MODE[NV] = '{0, 0, 0, 0, 1, 1, 2, 2, 2};
    localparam int V_PSC [NV] = '{0, 0, 3, 3, 0, 1, 0, 0, 3};
    localparam int V_ARR [NV] = '{54, 54, 54, 54, 10, 10, 8, 8, 5};
    localparam int V_K   [NV] = '{30, 60, 100, 230, 4, 30, 12, 5, 43};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [CNT_W-1:0] cnt_o;
    logic          upd_flag;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    tmr_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cnt_o(cnt_o), .upd_flag(upd_flag), .irq(irq)
    );

    function automatic logic [DW-1:0] ctrl(bit en, bit urs, int mode, bit uie);
        return DW'({uie, 2'(mode), urs, en});
    endfunction

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic wait_cyc(input int k);
        repeat (k) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic sample(input string req, input int ec, input int ef, input int ei);
        @(negedge clk);
        check(req, "cnt", int'(cnt_o), ec);
        check(req, "flag", int'(upd_flag), ef);
        check(req, "irq", int'(irq), ei);
    endtask

    // R2: quiet software update with flag clear, then enable, in the given mode.
    task automatic setup(input int mode, input int p, input int a, input bit uie);
        wr(2'd0, ctrl(0, 1, mode, uie));
        wr(2'd1, DW'(p));
        wr(2'd2, DW'(a));
        wr(2'd3, DW'(1));
        wr(2'd0, ctrl(1, 1, mode, uie));
    endtask

    function automatic int exp_cnt(int mode, int p, int a, int k);
        int t = k / (p + 1);
        int ph;
        if (mode == 1) return ((a - t) % (a + 1) + (a + 1)) % (a + 1);
        if (mode == 2) begin
            ph = t % (2 * a);
            return (ph <= a) ? ph : 2 * a - ph;
        end
        return t % (a + 1);
    endfunction

    function automatic int exp_flag(int mode, int p, int a, int k);
        int t = k / (p + 1);
        return (mode == 2) ? int'(t >= a) : int'(t >= a + 1);
    endfunction

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=timeout exp=finish");
        finish_run();
    end

    initial begin
        string tag;
        int c0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        // R1: reset state
        sample("R1", 0, 0, 0);

        // Table walk: R3 up, R4 down, R5 center, R6 division; irq follows flag (R11)
        for (int i = 0; i < NV; i++) begin
            tag = (V_MODE[i] == 0) ? "R3/R6" : (V_MODE[i] == 1) ? "R4/R6" : "R5/R6";
            setup(V_MODE[i], V_PSC[i], V_ARR[i], 1'b1);
            wait_cyc(V_K[i]);
            sample(tag, exp_cnt(V_MODE[i], V_PSC[i], V_ARR[i], V_K[i]),
                   exp_flag(V_MODE[i], V_PSC[i], V_ARR[i], V_K[i]),
                   exp_flag(V_MODE[i], V_PSC[i], V_ARR[i], V_K[i]));
        end

        // R7: a new limit waits for the wrap, then the next period uses it
        setup(0, 0, 20, 1'b0);
        wait_cyc(3);
        wr(2'd2, DW'(5));
        wait_cyc(6);
        sample("R7", 10, 0, 0);
        wait_cyc(11);
        sample("R7", 0, 1, 0);
        wait_cyc(6);
        sample("R7", 0, 1, 0);
        wait_cyc(3);
        sample("R7", 3, 1, 0);

        // R8: software update restarts the counter and the divide-by-4 count
        setup(0, 3, 50, 1'b1);
        wait_cyc(10);
        wr(2'd3, DW'(3));
        wait_cyc(3);
        sample("R8", 0, 0, 0);
        wait_cyc(1);
        sample("R8", 1, 0, 0);

        // R9: a software update with quiet select 0 sets the flag
        wr(2'd0, ctrl(1, 0, 0, 1));
        wr(2'd3, DW'(3));
        @(negedge clk);
        check("R9", "flag", int'(upd_flag), 1);
        check("R11", "irq", int'(irq), 1);
        wr(2'd0, ctrl(1, 0, 0, 0));
        @(negedge clk);
        check("R11", "irq_masked", int'(irq), 0);
        // R10: bit 1 = 1 keeps the flag, bit 1 = 0 clears it
        wr(2'd3, DW'(2));
        @(negedge clk);
        check("R10", "flag_keep", int'(upd_flag), 1);
        wr(2'd3, DW'(0));
        @(negedge clk);
        check("R10", "flag_clear", int'(upd_flag), 0);

        // R12: disabled counter holds its value
        wr(2'd0, ctrl(0, 1, 0, 0));
        @(negedge clk);
        c0 = int'(cnt_o);
        wait_cyc(20);
        @(negedge clk);
        check("R12", "cnt_hold", int'(cnt_o), c0);

        // R8: software update while disabled, down mode loads the new limit
        wr(2'd0, ctrl(0, 1, 1, 0));
        wr(2'd2, DW'(33));
        wr(2'd3, DW'(1));
        @(negedge clk);
        check("R8", "down_load", int'(cnt_o), 33);
        check("R9", "quiet_flag", int'(upd_flag), 0);
        wait_cyc(5);
        @(negedge clk);
        check("R12", "still_hold", int'(cnt_o), 33);

        finish_run();
    end
endmodule